// File: doc/BRIEF.md
# Shift, Rotate and Nibble-Exchange Unit

This block is the data path for the read-modify-write shift and rotate operations of a small processor. One operand, 8 or 16 bits wide, is presented with a valid strobe, together with the current carry flag and the accumulator. The block applies one of eight single-bit shifts or rotates, or one of two 4-bit nibble exchanges between the accumulator and a byte operand. One clock later it presents a registered result. That result holds the value to write back, the new accumulator, the S, Z, H, N, P/V and C flags and the number of cycles the operation costs.

A 4-bit operation code selects the function and a size bit selects byte or word. Address generation and the memory access itself belong to the surrounding core. Code values and size combinations that have no meaning are flagged rather than executed.

Top module: `shrot_unit`

## Requirements
- R1: Code 0 rotates left circularly: the old MSB goes to both bit 0 and C. Code 1 rotates right circularly: the old bit 0 goes to both the MSB and C.
- R2: Code 2 rotates left through carry: carry_in fills bit 0 and the old MSB becomes C. Code 3 rotates right through carry: carry_in fills the MSB and the old bit 0 becomes C.
- R3: Code 5 shifts right arithmetically and keeps the sign bit. Code 7 shifts right logically and fills the MSB with 0. Both put the old bit 0 in C.
- R4: Codes 4 and 6 shift left. Both fill bit 0 with 0 and put the old MSB in C.
- R5: Code 8, in byte size only, is the left nibble exchange. The new acc_out low nibble is the operand high nibble. The new result is {operand low nibble, old acc low nibble}. The acc high nibble is unchanged.
- R6: Code 9, in byte size only, is the right nibble exchange. The new acc_out low nibble is the operand low nibble. The new result is {old acc low nibble, operand high nibble}. The acc high nibble is unchanged.
- R7: For codes 0 to 7, S is the result MSB at the operand width, Z is 1 for a zero result, P/V is 1 for an even number of ones in the result, and H and N are 0.
- R8: For codes 8 and 9, S, Z and P/V are taken from the new accumulator, H and N are 0, and C equals carry_in. For codes 0 to 7, acc_out equals acc_in.
- R9: The cycles output is 12 for codes 8 and 9, 8 for codes 0 to 7, and 0 for an illegal request.
- R10: out_valid is high exactly in the cycle after a cycle with in_valid high. While out_valid is low, every other output keeps its last value.
- R11: With wide = 0 only operand[7:0] is used, the MSB is bit 7, and result[15:8] is 0. With wide = 1 all 16 bits are used and the MSB is bit 15.
- R12: Codes 10 to 15, and codes 8 or 9 with wide = 1, raise illegal. In that case result equals the operand, acc_out equals acc_in, C equals carry_in and S, Z, H, N, P/V are 0.
- R13: After a synchronous active-low reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand and controls are valid this cycle |
| op | input | 4 | Operation code |
| wide | input | 1 | 0 = byte, 1 = word |
| operand | input | WORD_W (16) | Value read from memory |
| acc_in | input | BYTE_W (8) | Current accumulator |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Registered result is valid |
| result | output | WORD_W (16) | Value to write back |
| acc_out | output | BYTE_W (8) | New accumulator |
| flag_s | output | 1 | Sign |
| flag_z | output | 1 | Zero |
| flag_h | output | 1 | Half carry |
| flag_n | output | 1 | Subtract |
| flag_pv | output | 1 | Even parity |
| flag_c | output | 1 | Carry |
| cycles | output | CYC_W (4) | Cycle cost of the operation |
| illegal | output | 1 | Request was not a valid operation |

## Verification
The assertions assume that op, wide, operand, acc_in and carry_in are known in every cycle where in_valid is high. They also use $past of those inputs at the cycle the result appears, so they rely on the inputs being sampled exactly one edge earlier. The stimulus drives every input on the falling edge. It draws the operation code across all sixteen values, so illegal codes and word-size nibble requests are exercised. In byte mode it fills the upper operand byte with random data, so that the upper byte is seen to be ignored.

// File: rtl/shrot_pkg.sv
// Shared operation codes and flag bundle for the shift/rotate unit.
// Assumes a 4-bit operation code; codes above OP_NIB_R are illegal.
package shrot_pkg;

    typedef enum logic [3:0] {
        OP_ROL_CIRC  = 4'd0,
        OP_ROR_CIRC  = 4'd1,
        OP_ROL_CARRY = 4'd2,
        OP_ROR_CARRY = 4'd3,
        OP_SHL_ARITH = 4'd4,
        OP_SHR_ARITH = 4'd5,
        OP_SHL_LOGIC = 4'd6,
        OP_SHR_LOGIC = 4'd7,
        OP_NIB_L     = 4'd8,
        OP_NIB_R     = 4'd9
    } shrot_op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic h;
        logic n;
        logic pv;
        logic c;
    } shrot_flags_t;

endpackage

// File: rtl/shrot_bitmove.sv
// Single-bit shift or rotate of a W-bit value.
// sel is the low three bits of the operation code; the caller decides
// whether the code is a shift at all. Purely combinational.
module shrot_bitmove #(
    parameter int W = 8
) (
    input  logic [W-1:0] data,
    input  logic [2:0]   sel,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    // Move bits according to the selected shift or rotate.
    always_comb begin
        case (sel)
            3'd0: begin res = {data[W-2:0], data[W-1]}; cout = data[W-1]; end
            3'd1: begin res = {data[0], data[W-1:1]};   cout = data[0];   end
            3'd2: begin res = {data[W-2:0], cin};       cout = data[W-1]; end
            3'd3: begin res = {cin, data[W-1:1]};       cout = data[0];   end
            3'd5: begin res = {data[W-1], data[W-1:1]}; cout = data[0];   end
            3'd7: begin res = {1'b0, data[W-1:1]};      cout = data[0];   end
            default: begin res = {data[W-2:0], 1'b0};   cout = data[W-1]; end
        endcase
    end
endmodule

// File: rtl/shrot_nibble.sv
// Nibble exchange between the accumulator and a byte operand.
// dir = 0 moves nibbles leftwards through memory, dir = 1 rightwards.
// The accumulator high half is always passed through. Combinational.
module shrot_nibble #(
    parameter int BW = 8
) (
    input  logic [BW-1:0] mem_in,
    input  logic [BW-1:0] acc_in,
    input  logic          dir,
    output logic [BW-1:0] mem_new,
    output logic [BW-1:0] acc_new
);
    localparam int NW = BW / 2;

    // Route the three low/high halves for the chosen direction.
    always_comb begin
        if (!dir) begin
            acc_new = {acc_in[BW-1:NW], mem_in[BW-1:NW]};
            mem_new = {mem_in[NW-1:0], acc_in[NW-1:0]};
        end else begin
            acc_new = {acc_in[BW-1:NW], mem_in[NW-1:0]};
            mem_new = {acc_in[NW-1:0], mem_in[BW-1:NW]};
        end
    end
endmodule

// File: rtl/shrot_flags.sv
// Sign, zero and even-parity of a W-bit value. Combinational.
module shrot_flags #(
    parameter int W = 8
) (
    input  logic [W-1:0] value,
    output logic         sign,
    output logic         zero,
    output logic         even
);
    // Derive the three value-based flags.
    always_comb begin
        sign = value[W-1];
        zero = (value == '0);
        even = ~^value;
    end
endmodule

// File: rtl/shrot_unit.sv
// Shift/rotate/nibble-exchange unit with a registered output stage.
// Assumes inputs are stable around the edge where in_valid is sampled.
// Outputs hold their last values while no request arrives.
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int CYC_SH  = 8,
    parameter int CYC_NIB = 12,
    parameter int BYTE_W  = WORD_W / 2,
    parameter int CYC_W   = $clog2(CYC_NIB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic              wide,
    input  logic [WORD_W-1:0] operand,
    input  logic [BYTE_W-1:0] acc_in,
    input  logic              carry_in,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic [BYTE_W-1:0] acc_out,
    output logic              flag_s,
    output logic              flag_z,
    output logic              flag_h,
    output logic              flag_n,
    output logic              flag_pv,
    output logic              flag_c,
    output logic [CYC_W-1:0]  cycles,
    output logic              illegal
);
    localparam int NSIZE = 2;
    localparam int EXT_W = WORD_W - BYTE_W;

    logic [WORD_W-1:0] mv_res [NSIZE];
    logic              mv_c   [NSIZE];
    logic              vf_s   [NSIZE];
    logic              vf_z   [NSIZE];
    logic              vf_p   [NSIZE];

    // One shift engine and one flag block per operand size.
    for (genvar g = 0; g < NSIZE; g++) begin : g_size
        localparam int SW = (g == 0) ? BYTE_W : WORD_W;
        logic [SW-1:0] r;
        shrot_bitmove #(.W(SW)) u_mv (
            .data (operand[SW-1:0]),
            .sel  (op[2:0]),
            .cin  (carry_in),
            .res  (r),
            .cout (mv_c[g])
        );
        shrot_flags #(.W(SW)) u_fl (
            .value (r),
            .sign  (vf_s[g]),
            .zero  (vf_z[g]),
            .even  (vf_p[g])
        );
        if (SW == WORD_W) begin : g_full
            assign mv_res[g] = r;
        end else begin : g_ext
            assign mv_res[g] = {{EXT_W{1'b0}}, r};
        end
    end

    logic [BYTE_W-1:0] nb_mem, nb_acc;
    logic              na_s, na_z, na_p;

    shrot_nibble #(.BW(BYTE_W)) u_nib (
        .mem_in  (operand[BYTE_W-1:0]),
        .acc_in  (acc_in),
        .dir     (op[0]),
        .mem_new (nb_mem),
        .acc_new (nb_acc)
    );

    shrot_flags #(.W(BYTE_W)) u_accfl (
        .value (nb_acc),
        .sign  (na_s),
        .zero  (na_z),
        .even  (na_p)
    );

    logic              is_shift, is_nib, bad;
    logic              sz;
    logic [WORD_W-1:0] nx_res;
    logic [BYTE_W-1:0] nx_acc;
    shrot_flags_t      nx_fl;
    logic [CYC_W-1:0]  nx_cyc;

    // Classify the request from code and size.
    always_comb begin
        is_shift = (op[3] == 1'b0);
        is_nib   = (op == OP_NIB_L || op == OP_NIB_R) && !wide;
        bad      = !is_shift && !is_nib;
        sz       = wide;
    end

    // Select the next result, accumulator, flags and cycle cost.
    always_comb begin
        nx_fl   = '0;
        nx_res  = operand;
        nx_acc  = acc_in;
        nx_cyc  = '0;
        nx_fl.c = carry_in;
        if (is_shift) begin
            nx_res   = mv_res[sz];
            nx_fl.s  = vf_s[sz];
            nx_fl.z  = vf_z[sz];
            nx_fl.pv = vf_p[sz];
            nx_fl.c  = mv_c[sz];
            nx_cyc   = CYC_W'(CYC_SH);
        end else if (is_nib) begin
            nx_res   = {{EXT_W{1'b0}}, nb_mem};
            nx_acc   = nb_acc;
            nx_fl.s  = na_s;
            nx_fl.z  = na_z;
            nx_fl.pv = na_p;
            nx_cyc   = CYC_W'(CYC_NIB);
        end
    end

    // Output stage: capture on a request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            acc_out   <= '0;
            flag_s    <= 1'b0;
            flag_z    <= 1'b0;
            flag_h    <= 1'b0;
            flag_n    <= 1'b0;
            flag_pv   <= 1'b0;
            flag_c    <= 1'b0;
            cycles    <= '0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= nx_res;
                acc_out <= nx_acc;
                flag_s  <= nx_fl.s;
                flag_z  <= nx_fl.z;
                flag_h  <= nx_fl.h;
                flag_n  <= nx_fl.n;
                flag_pv <= nx_fl.pv;
                flag_c  <= nx_fl.c;
                cycles  <= nx_cyc;
                illegal <= bad;
            end
        end
    end
endmodule

// File: rtl/shrot_unit_chk.sv
// Property checker for shrot_unit, attached by bind below.
// Assumes inputs are known whenever in_valid is high.
module shrot_unit_chk #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8,
    parameter int CYC_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        op,
    input logic              wide,
    input logic [WORD_W-1:0] operand,
    input logic [BYTE_W-1:0] acc_in,
    input logic              carry_in,
    input logic              out_valid,
    input logic [WORD_W-1:0] result,
    input logic [BYTE_W-1:0] acc_out,
    input logic              flag_s,
    input logic              flag_z,
    input logic              flag_h,
    input logic              flag_n,
    input logic              flag_pv,
    input logic              flag_c,
    input logic [CYC_W-1:0]  cycles,
    input logic              illegal
);
    localparam int NW = BYTE_W / 2;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R10
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result) && $stable(acc_out) && $stable(cycles)); // R10
    AST_HN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !flag_h && !flag_n); // R7
    AST_SHIFT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !illegal && !$past(op[3]) |-> flag_z == (result == '0)); // R7
    AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !$past(wide) && !illegal |-> result[WORD_W-1:BYTE_W] == '0); // R11
    AST_NIB_ACC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !illegal && $past(op[3]) |->
        acc_out[BYTE_W-1:NW] == $past(acc_in[BYTE_W-1:NW])); // R5
    AST_CYCLE_COST: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !illegal |-> cycles == (($past(op[3])) ? CYC_W'(12) : CYC_W'(8))); // R9
    AST_ILLEGAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && illegal |-> result == $past(operand) && flag_c == $past(carry_in)); // R12
    AST_SHIFT_ACC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !$past(op[3]) |-> acc_out == $past(acc_in)); // R8
endmodule

bind shrot_unit shrot_unit_chk #(
    .WORD_W (WORD_W),
    .BYTE_W (BYTE_W),
    .CYC_W  (CYC_W)
) u_chk (.*);

// File: tb/shrot_unit_test.sv
`timescale 1ns/1ps
module shrot_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic        wide = 1'b0;
    logic [15:0] operand = '0;
    logic [7:0]  acc_in = '0;
    logic        carry_in = 1'b0;
    logic        out_valid;
    logic [15:0] result;
    logic [7:0]  acc_out;
    logic        flag_s, flag_z, flag_h, flag_n, flag_pv, flag_c;
    logic [3:0]  cycles;
    logic        illegal;

    int total = 0;
    int bad = 0;

    shrot_unit uut (.*);

    always #2.5 clk = ~clk;

    // expected values
    logic [15:0] e_res;
    logic [7:0]  e_acc;
    logic        e_s, e_z, e_pv, e_c, e_ill;
    logic [3:0]  e_cyc;

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic even16(input logic [15:0] v);
        int n = 0;
        for (int i = 0; i < 16; i++) n += int'(v[i]);
        return (n % 2) == 0;
    endfunction

    function automatic string tag(input logic [3:0] o, input logic w);
        if (o > 4'd9 || (o >= 4'd8 && w)) return "R12";
        case (o)
            4'd0, 4'd1: return "R1";
            4'd2, 4'd3: return "R2";
            4'd5, 4'd7: return "R3";
            4'd4, 4'd6: return "R4";
            4'd8: return "R5";
            default: return "R6";
        endcase
    endfunction

    // Reference model written from the requirements.
    task automatic model(input logic [3:0] o, input logic w, input logic [15:0] d_in,
                         input logic [7:0] a, input logic ci);
        int msb = w ? 15 : 7;
        logic [15:0] mask = w ? 16'hFFFF : 16'h00FF;
        logic [15:0] d = d_in & mask;
        logic top = d[msb];
        logic low = d[0];
        e_ill = (o > 4'd9) || (o >= 4'd8 && w);
        e_acc = a; e_c = ci; e_s = 0; e_z = 0; e_pv = 0; e_cyc = 0; e_res = d_in;
        if (!e_ill && o < 4'd8) begin
            case (o)
                4'd0: begin e_res = ((d << 1) | 16'(top)) & mask; e_c = top; end
                4'd1: begin e_res = (d >> 1) | (16'(top ? 0 : 0)) | (low ? (16'd1 << msb) : 16'd0); e_c = low; end
                4'd2: begin e_res = ((d << 1) | 16'(ci)) & mask; e_c = top; end
                4'd3: begin e_res = (d >> 1) | (ci ? (16'd1 << msb) : 16'd0); e_c = ci ? low : low; end
                4'd4, 4'd6: begin e_res = (d << 1) & mask; e_c = top; end
                4'd5: begin e_res = (d >> 1) | (top ? (16'd1 << msb) : 16'd0); e_c = low; end
                default: begin e_res = d >> 1; e_c = low; end
            endcase
            e_s = e_res[msb]; e_z = (e_res == 0); e_pv = even16(e_res); e_cyc = 4'd8;
        end else if (!e_ill) begin
            if (o == 4'd8) begin
                e_acc = {a[7:4], d[7:4]};
                e_res = {8'h00, d[3:0], a[3:0]};
            end else begin
                e_acc = {a[7:4], d[3:0]};
                e_res = {8'h00, a[3:0], d[7:4]};
            end
            e_s = e_acc[7]; e_z = (e_acc == 0); e_pv = even16({8'h00, e_acc}); e_cyc = 4'd12;
        end
    endtask

    // Drive one request on a falling edge, check after the next rising edge.
    task automatic run(input logic [3:0] o, input logic w, input logic [15:0] d,
                       input logic [7:0] a, input logic ci);
        string t = tag(o, w);
        model(o, w, d, a, ci);
        @(negedge clk);
        op = o; wide = w; operand = d; acc_in = a; carry_in = ci; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid === 1'b1, "R10", "out_valid", 16'(out_valid), 16'd1);
        chk(result === e_res, t, "result", result, e_res);
        chk(acc_out === e_acc, (o >= 4'd8 && !e_ill) ? t : "R8", "acc_out", 16'(acc_out), 16'(e_acc));
        chk(flag_c === e_c, t, "carry", 16'(flag_c), 16'(e_c));
        chk({flag_s, flag_z, flag_pv} === {e_s, e_z, e_pv}, (o >= 4'd8) ? "R8" : "R7",
            "s/z/pv", 16'({flag_s, flag_z, flag_pv}), 16'({e_s, e_z, e_pv}));
        chk({flag_h, flag_n} === 2'b00, "R7", "h/n", 16'({flag_h, flag_n}), 16'd0);
        chk(cycles === e_cyc, "R9", "cycles", 16'(cycles), 16'(e_cyc));
        chk(illegal === e_ill, "R12", "illegal", 16'(illegal), 16'(e_ill));
    endtask

    initial begin : watchdog
        #400000;
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [15:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R13: reset state
        chk({out_valid, result, acc_out, flag_s, flag_z, flag_h, flag_n, flag_pv, flag_c, cycles, illegal} === '0,
            "R13", "reset outputs", result, 16'd0);
        rst_n = 1'b1;

        // Directed corners
        run(4'd0, 1'b0, 16'hAB80, 8'h00, 1'b0); // R1 byte MSB wraps, upper ignored (R11)
        run(4'd1, 1'b1, 16'h0001, 8'h00, 1'b0); // R1 word bit 0 wraps to bit 15
        run(4'd2, 1'b0, 16'h0080, 8'h00, 1'b0); // R2 result zero, carry out set
        run(4'd3, 1'b1, 16'h0000, 8'h00, 1'b1); // R2 carry into bit 15
        run(4'd5, 1'b0, 16'h0080, 8'h00, 1'b0); // R3 sign kept
        run(4'd7, 1'b1, 16'h8001, 8'h00, 1'b0); // R3 logical fill
        run(4'd4, 1'b1, 16'hC000, 8'h00, 1'b0); // R4 word
        run(4'd6, 1'b0, 16'hFF01, 8'h00, 1'b1); // R4 byte, upper ignored (R11)
        run(4'd8, 1'b0, 16'h0034, 8'h12, 1'b1); // R5 -> acc 13, mem 42
        run(4'd9, 1'b0, 16'h0034, 8'h12, 1'b0); // R6 -> acc 14, mem 23
        run(4'd9, 1'b0, 16'h0000, 8'h00, 1'b1); // R8 zero acc
        run(4'd8, 1'b1, 16'h1234, 8'h55, 1'b1); // R12 nibble at word size
        run(4'd14, 1'b0, 16'hBEEF, 8'hA5, 1'b0); // R12 undefined code

        // R10: outputs hold while idle
        held = result;
        @(negedge clk);
        operand = 16'h5A5A; op = 4'd0;
        @(negedge clk);
        chk(out_valid === 1'b0, "R10", "idle out_valid", 16'(out_valid), 16'd0);
        chk(result === held, "R10", "idle hold", result, held);

        // Random mix
        for (int i = 0; i < 600; i++) begin
            run(4'($urandom % 16), 1'($urandom), 16'($urandom), 8'($urandom), 1'($urandom));
        end

        // R13 again: mid-run reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk({out_valid, result, cycles} === '0, "R13", "reset again", result, 16'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule